// File: doc/BRIEF.md
# Stereo Audio Serial Port Control Front End

This block sits between a simple register bus and the data path of a stereo audio serial port. A control register holds a port enable, one interrupt mask for each of six FIFO service-request lines, a loopback switch and two pin polarity selects. The FIFOs report their service requests as level inputs. The block merges the unmasked requests into one registered interrupt line. The raw request levels can always be read back, whatever the masks hold.

The block also holds the serial shift register. The bus loads a word into it, and each shift tick moves it one place towards the MSB. The MSB drives the serial data output. In normal operation the LSB takes the serial data input. In loopback the MSB feeds the LSB, so the word rotates in place. The block then drives its serial data, bit clock and frame clock outputs low and raises a select output that hands those pins to a separate pin owner. The port enable is the only control bit with a reset value. Software must write every other control bit before it sets the enable.

Top module: `aspc_top`

## Requirements
- R1: After a synchronous active-low reset, the enable bit (control bit 0) reads 0 and `irq_o` is 0.
- R2: Control register (address 0) bits 15:10 are reserved. Writes to them have no effect and they read 0. Bits 9:0 read back as written: bit 0 enable, bit 1 loopback, bits 7:2 mask for request 0..5, bit 8 bit-clock invert, bit 9 frame-clock invert.
- R3: A request whose mask bit is 0 never causes `irq_o` to be asserted.
- R4: With the port enabled, `irq_o` is 1 one clock after any request whose mask bit is 1 is high, and 0 one clock after no such pair is high.
- R5: The status register (address 1, bits 5:0) shows the request inputs whenever the port is enabled, whatever the mask bits hold.
- R6: In loopback, each shift tick rotates the shift word left by one, so after WORD_W ticks the received word (address 3) equals the loaded word, and `sdin_i` is ignored.
- R7: In loopback, `pin_sel_o` is 1 and `sdout_o`, `sclk_o` and `lrck_o` are 0.
- R8: Outside loopback, `pin_sel_o` is 0, `sdout_o` is the shift-word MSB, each tick shifts `sdin_i` into the LSB, and `sclk_o`/`lrck_o` are `bclk_i`/`frame_i` XOR their invert bits.
- R9: While the enable bit is 0, shift ticks leave the shift word unchanged, the status reads 0 and `irq_o` stays 0. Register writes and loads of the shift word (address 2) still take effect.
- R10: When the enable bit is set, no other control bit is unknown.
- R11: A write to address 2 in the same cycle as a shift tick loads the written word unshifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cs_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | Bus write (1) or read (0) |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register |
| fifo_req_i | input | 6 | FIFO service-request levels |
| shift_tick_i | input | 1 | Shift strobe from the clock generator |
| bclk_i | input | 1 | Bit clock from the clock generator |
| frame_i | input | 1 | Frame clock from the clock generator |
| sdin_i | input | 1 | Serial data input pin |
| sdout_o | output | 1 | Serial data output pin |
| sclk_o | output | 1 | Bit clock output pin |
| lrck_o | output | 1 | Frame clock output pin |
| pin_sel_o | output | 1 | 1 hands the serial pins to the separate pin owner |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
The shift path has two writers that can act in the same cycle: a bus load of the shift word and a shift tick from the clock generator. The bench raises the tick and a write to address 2 in one cycle with the port enabled. It then reads address 3 and expects exactly the written word, not a word shifted by one. A second overlap sets a mask bit in the same cycle that a request is already high. The bench expects `irq_o` to rise only after the new mask is in place.

// File: rtl/aspc_pkg.sv
`timescale 1ns/1ps
// Shared constants and the control register layout for the audio serial
// port front end. Assumes a 16-bit register bus with four word addresses.
package aspc_pkg;
    localparam int NREQ   = 6;          // FIFO service-request lines
    localparam int CTRL_W = NREQ + 4;   // enable, loopback, masks, two inverts
    localparam int REG_W  = 16;         // bus data width
    localparam int ADDR_W = 2;          // bus address width

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_TXLD = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_RXWD = ADDR_W'(3);

    typedef struct packed {
        logic            lrck_inv;
        logic            sclk_inv;
        logic [NREQ-1:0] mask;
        logic            lb;
        logic            en;
    } ctrl_t;
endpackage

// File: rtl/aspc_ctrl_reg.sv
`timescale 1ns/1ps
// Control register. Only the enable bit is reset; all other fields power up
// unknown and are expected to be written by software before enabling.
// Assumes wr_i is a single-cycle qualified write strobe.
module aspc_ctrl_reg
    import aspc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wdata_i,
    output ctrl_t             ctrl_o
);
    logic              en_q;
    logic [CTRL_W-2:0] rest_q;

    // Enable bit: the only field with a defined reset value.
    always_ff @(posedge clk) begin
        if (!rst_n)    en_q <= 1'b0;
        else if (wr_i) en_q <= wdata_i[0];
    end

    // Remaining fields: no reset, loaded on every control write.
    always_ff @(posedge clk) begin
        if (wr_i) rest_q <= wdata_i[CTRL_W-1:1];
    end

    assign ctrl_o = {rest_q, en_q};

    // R10: enabling the port with unwritten fields is a software error.
    p_fields_known_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> !$isunknown(rest_q));
endmodule

// File: rtl/aspc_irq.sv
`timescale 1ns/1ps
// Status gating and interrupt combiner. Status follows the request inputs
// while enabled; masks gate only the interrupt, never the status.
// The interrupt is registered so that the output is glitch-free.
module aspc_irq
    import aspc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [NREQ-1:0] req_i,
    input  logic [NREQ-1:0] mask_i,
    output logic [NREQ-1:0] stat_o,
    output logic            irq_o
);
    logic [NREQ-1:0] hit;
    logic            irq_q;

    // Status is forced to zero while the port is disabled.
    assign stat_o = en_i ? req_i : '0;

    // One gate per request line.
    for (genvar i = 0; i < NREQ; i++) begin : g_hit
        assign hit[i] = stat_o[i] & mask_i[i];
    end

    // Registered OR of all unmasked requests.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |hit;
    end

    assign irq_o = irq_q;

    // R3: no unmasked active request means no interrupt next cycle.
    p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_o & mask_i) == '0) |=> !irq_o);
    // R4: an unmasked active request raises the interrupt next cycle.
    p_unmasked_fires_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_o & mask_i) != '0) |=> irq_o);
endmodule

// File: rtl/aspc_shifter.sv
`timescale 1ns/1ps
// Serial shift register. A bus load has priority over a shift tick; ticks
// act only while enabled. In loopback the MSB feeds the LSB.
module aspc_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              lb_i,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_word_i,
    input  logic              sdin_i,
    output logic [WORD_W-1:0] word_o,
    output logic              msb_o
);
    localparam int MSB = WORD_W - 1;

    logic [WORD_W-1:0] sh_q;
    logic              in_bit;

    // Loopback mux on the incoming LSB.
    assign in_bit = lb_i ? sh_q[MSB] : sdin_i;

    // Load wins over shift; hold while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)             sh_q <= '0;
        else if (load_i)        sh_q <= load_word_i;
        else if (en_i && tick_i) sh_q <= {sh_q[MSB-1:0], in_bit};
    end

    assign word_o = sh_q;
    assign msb_o  = sh_q[MSB];

    // R9: disabled with no load, the word must not move.
    p_hold_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i) |=> $stable(sh_q));
    // R6: in loopback a tick moves the old MSB into the LSB.
    p_loop_rotate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && lb_i && tick_i && !load_i) |=> (sh_q[0] == $past(sh_q[MSB])));
endmodule

// File: rtl/aspc_pins.sv
`timescale 1ns/1ps
// Serial pin drive. Applies polarity selects outside loopback and releases
// the pins (driven low, select raised) while loopback is on.
module aspc_pins (
    input  logic lb_i,
    input  logic sclk_inv_i,
    input  logic lrck_inv_i,
    input  logic bclk_i,
    input  logic frame_i,
    input  logic msb_i,
    output logic sdout_o,
    output logic sclk_o,
    output logic lrck_o,
    output logic pin_sel_o
);
    // Pin values: owned here unless loopback hands them away.
    always_comb begin
        pin_sel_o = lb_i;
        sdout_o   = lb_i ? 1'b0 : msb_i;
        sclk_o    = lb_i ? 1'b0 : (bclk_i ^ sclk_inv_i);
        lrck_o    = lb_i ? 1'b0 : (frame_i ^ lrck_inv_i);
    end
endmodule

// File: rtl/aspc_top.sv
`timescale 1ns/1ps
// Audio serial port control front end: register decode, status/interrupt
// combining, shift path with loopback, and serial pin drive.
// Assumes reads are combinational on the address; writes take one edge.
module aspc_top
    import aspc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    input  logic [NREQ-1:0]   fifo_req_i,
    input  logic              shift_tick_i,
    input  logic              bclk_i,
    input  logic              frame_i,
    input  logic              sdin_i,
    output logic              sdout_o,
    output logic              sclk_o,
    output logic              lrck_o,
    output logic              pin_sel_o,
    output logic              irq_o
);
    ctrl_t             ctrl;
    logic              wr;
    logic              wr_ctrl;
    logic              wr_load;
    logic [NREQ-1:0]   stat;
    logic [WORD_W-1:0] word;
    logic              msb;
    logic [REG_W-1:0]  ctrl_ext;
    logic [REG_W-1:0]  stat_ext;
    logic [REG_W-1:0]  word_ext;

    assign wr      = bus_cs_i && bus_we_i;
    assign wr_ctrl = wr && (bus_addr_i == A_CTRL);
    assign wr_load = wr && (bus_addr_i == A_TXLD);

    aspc_ctrl_reg i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_ctrl),
        .wdata_i (bus_wdata_i[CTRL_W-1:0]),
        .ctrl_o  (ctrl)
    );

    aspc_irq i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctrl.en),
        .req_i  (fifo_req_i),
        .mask_i (ctrl.mask),
        .stat_o (stat),
        .irq_o  (irq_o)
    );

    aspc_shifter #(.WORD_W(WORD_W)) i_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (ctrl.en),
        .lb_i        (ctrl.lb),
        .tick_i      (shift_tick_i),
        .load_i      (wr_load),
        .load_word_i (bus_wdata_i[WORD_W-1:0]),
        .sdin_i      (sdin_i),
        .word_o      (word),
        .msb_o       (msb)
    );

    aspc_pins i_pins (
        .lb_i       (ctrl.lb),
        .sclk_inv_i (ctrl.sclk_inv),
        .lrck_inv_i (ctrl.lrck_inv),
        .bclk_i     (bclk_i),
        .frame_i    (frame_i),
        .msb_i      (msb),
        .sdout_o    (sdout_o),
        .sclk_o     (sclk_o),
        .lrck_o     (lrck_o),
        .pin_sel_o  (pin_sel_o)
    );

    // Zero-extend each readable register to the bus width.
    always_comb begin
        ctrl_ext = '0;
        ctrl_ext[CTRL_W-1:0] = ctrl;
        stat_ext = '0;
        stat_ext[NREQ-1:0] = stat;
        word_ext = '0;
        word_ext[WORD_W-1:0] = word;
    end

    // Read mux; the load address reads as zero.
    always_comb begin
        case (bus_addr_i)
            A_CTRL:  bus_rdata_o = ctrl_ext;
            A_STAT:  bus_rdata_o = stat_ext;
            A_RXWD:  bus_rdata_o = word_ext;
            default: bus_rdata_o = '0;
        endcase
    end
endmodule

// File: tb/test_aspc_top.sv
`timescale 1ns/1ps
module test_aspc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_i = 1'b0;
    logic        bus_we_i = 1'b0;
    logic [1:0]  bus_addr_i = 2'd0;
    logic [15:0] bus_wdata_i = 16'h0;
    logic [15:0] bus_rdata_o;
    logic [5:0]  fifo_req_i = 6'h0;
    logic        shift_tick_i = 1'b0;
    logic        bclk_i = 1'b0;
    logic        frame_i = 1'b0;
    logic        sdin_i = 1'b0;
    logic        sdout_o, sclk_o, lrck_o, pin_sel_o, irq_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    aspc_top i_aspc_top (
        .clk(clk), .rst_n(rst_n), .bus_cs_i(bus_cs_i), .bus_we_i(bus_we_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .fifo_req_i(fifo_req_i), .shift_tick_i(shift_tick_i), .bclk_i(bclk_i),
        .frame_i(frame_i), .sdin_i(sdin_i), .sdout_o(sdout_o), .sclk_o(sclk_o),
        .lrck_o(lrck_o), .pin_sel_o(pin_sel_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_cs_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_cs_i = 1'b0; bus_we_i = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_cs_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
        #1 d = bus_rdata_o;
        bus_cs_i = 1'b0;
    endtask

    task automatic tick(input logic din);
        @(negedge clk);
        sdin_i = din; shift_tick_i = 1'b1;
        @(negedge clk);
        shift_tick_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_rd(2'd0, v);
        chk("R1 enable after reset", {15'h0, v[0]}, 16'h0);
        chk("R1 irq after reset", {15'h0, irq_o}, 16'h0);
    endtask

    task automatic t_reserved();
        logic [15:0] v;
        bus_wr(2'd0, 16'hFCFC);
        bus_rd(2'd0, v);
        chk("R2 reserved ignored, fields kept", v, 16'h00FC);
        chk("R10 fields known", {15'h0, $isunknown(v)}, 16'h0);
    endtask

    task automatic t_disabled();
        logic [15:0] v;
        fifo_req_i = 6'h3F;
        @(negedge clk);
        @(negedge clk);
        chk("R9 irq while disabled", {15'h0, irq_o}, 16'h0);
        bus_rd(2'd1, v);
        chk("R9 status while disabled", v, 16'h0);
        bus_wr(2'd2, 16'h1111);
        tick(1'b1); tick(1'b0); tick(1'b1);
        bus_rd(2'd3, v);
        chk("R9 shifter holds while disabled", v, 16'h1111);
        fifo_req_i = 6'h0;
    endtask

    task automatic t_mask();
        logic [15:0] v;
        bus_wr(2'd0, 16'h0001);
        fifo_req_i = 6'b000101;
        @(negedge clk);
        @(negedge clk);
        chk("R3 all masked no irq", {15'h0, irq_o}, 16'h0);
        bus_rd(2'd1, v);
        chk("R5 status with masks clear", v, 16'h0005);
        // Mask write lands while the request is already high.
        bus_wr(2'd0, 16'h0005);
        chk("R4 irq not before new mask acts", {15'h0, irq_o}, 16'h0);
        @(negedge clk);
        chk("R4 irq from unmasked request", {15'h0, irq_o}, 16'h1);
        bus_wr(2'd0, 16'h0009);
        @(negedge clk);
        chk("R3 idle line unmasked no irq", {15'h0, irq_o}, 16'h0);
        bus_rd(2'd1, v);
        chk("R5 status unchanged by mask", v, 16'h0005);
        bus_wr(2'd0, 16'h0011);
        @(negedge clk);
        chk("R4 irq request 2", {15'h0, irq_o}, 16'h1);
        fifo_req_i = 6'b000001;
        @(negedge clk);
        @(negedge clk);
        chk("R4 irq drops with request", {15'h0, irq_o}, 16'h0);
        fifo_req_i = 6'h0;
    endtask

    task automatic t_normal();
        logic [15:0] v;
        logic [15:0] a = 16'hA5C3;
        logic [15:0] b = 16'h3C96;
        bus_wr(2'd0, 16'h0001);
        bclk_i = 1'b1; frame_i = 1'b0;
        #1;
        chk("R8 pins normal", {12'h0, pin_sel_o, sclk_o, lrck_o, 1'b0}, 16'h0004);
        bus_wr(2'd0, 16'h0301);
        #1;
        chk("R8 pins inverted", {13'h0, pin_sel_o, sclk_o, lrck_o}, 16'h0001);
        bus_wr(2'd0, 16'h0001);
        bus_wr(2'd2, a);
        for (int i = 0; i < 16; i++) begin
            #1;
            if (sdout_o !== a[15-i]) chk("R8 sdout bit", {15'h0, sdout_o}, {15'h0, a[15-i]});
            tick(b[15-i]);
        end
        chk("R8 sdout sequence", 16'h0, 16'h0);
        bus_rd(2'd3, v);
        chk("R8 received word", v, b);
    endtask

    task automatic t_loop();
        logic [15:0] v;
        bus_wr(2'd0, 16'h0003);
        bclk_i = 1'b1; frame_i = 1'b1;
        #1;
        chk("R7 pins released", {12'h0, pin_sel_o, sdout_o, sclk_o, lrck_o}, 16'h0008);
        bus_wr(2'd2, 16'hA5C3);
        for (int i = 0; i < 4; i++) tick(1'b1);
        bus_rd(2'd3, v);
        chk("R6 rotate by four", v, 16'h5C3A);
        for (int i = 0; i < 12; i++) tick(1'b1);
        bus_rd(2'd3, v);
        chk("R6 loopback word returns", v, 16'hA5C3);
    endtask

    task automatic t_collide();
        logic [15:0] v;
        bus_wr(2'd0, 16'h0001);
        @(negedge clk);
        bus_cs_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = 2'd2; bus_wdata_i = 16'h1234;
        shift_tick_i = 1'b1; sdin_i = 1'b1;
        @(negedge clk);
        bus_cs_i = 1'b0; bus_we_i = 1'b0; shift_tick_i = 1'b0;
        bus_rd(2'd3, v);
        chk("R11 load wins over tick", v, 16'h1234);
    endtask

    initial begin
        #1600000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_reserved();
        t_disabled();
        t_mask();
        t_normal();
        t_loop();
        t_collide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule